// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This controller sits on the synchronous side of a chip and drives an external asynchronous static RAM with a 20-bit address and an 8-bit data path. A requester hands it one read or one write at a time over a valid/ready handshake. The controller then produces the chip-select pair, the write strobe and the output-enable strobe, holding each one for enough clock cycles to meet the memory's nanosecond limits. It returns either a one-cycle write-complete pulse or the read byte with a one-cycle valid pulse.

All nanosecond limits are parameters. At elaboration they are turned into cycle counts from the clock period parameter: the limit is divided by the period and rounded up, and the result is never less than one cycle. Writes are ended by the write strobe while output enable stays high. After a read, the controller deselects the memory and waits for the memory's output-float time before it drives the shared data lines again. When no request is pending it parks the memory deselected, in standby, with the data lines undriven.

The data bus is split into an output value, a drive-enable and an input value, so the pad tristate can be built outside the block.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever `req_ready` is high, the memory is deselected (`sram_ce1_n`=1, `sram_ce2`=0), `sram_we_n`=1, `sram_oe_n`=1 and `sram_dq_oe`=0.
- R2: A request is taken in a cycle where both `req_valid` and `req_ready` are high, with `req_write`=1 for a write and 0 for a read. `req_ready` then stays low until that access, including any turnaround, is complete.
- R3: A read holds the memory selected, with `sram_we_n`=1, `sram_oe_n`=0 and the address steady, for N_RD = max(ceil(T_AA/P), ceil(T_DOE/P), ceil(T_RC/P)) cycles. The input byte is captured at the end of that window and shown on `rd_data` with a single-cycle `rd_valid` pulse.
- R4: A write drives address and data with the memory selected and `sram_we_n`=1 for one cycle. It then holds `sram_we_n`=0 for N_WP cycles, and then keeps `sram_we_n`=1 for one more cycle with select, address and data unchanged. `sram_oe_n` stays 1 throughout, and the two strobes are never low together.
- R5: The write-strobe low time N_WP is at least ceil(T_PWE/P). The data is stable for at least ceil(T_SD/P) cycles before the strobe rises, and the address does not change while the strobe is low.
- R6: A write ends with a single-cycle `wr_done` pulse in the cycle after its hold cycle.
- R7: After a read, the controller keeps `sram_oe_n`=1 with the memory deselected for ceil(T_HZOE/P) cycles before it can drive `sram_dq_oe`=1.
- R8: `sram_dq_oe` is never 1 while `sram_oe_n` is 0.
- R9: Every cycle count is the nanosecond limit divided by `CLK_PERIOD_NS` and rounded up, with a minimum of one cycle.
- R10: Each access keeps the memory selected for at least ceil(T_RC/P) cycles for a read and ceil(T_WC/P) cycles for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| wr_done | output | 1 | Single-cycle write completion pulse |
| rd_valid | output | 1 | Single-cycle read data valid pulse |
| rd_data | output | DW | Captured read byte |
| sram_addr | output | AW | Memory address lines |
| sram_ce1_n | output | 1 | Active-low chip select |
| sram_ce2 | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq_out | output | DW | Data driven toward the memory |
| sram_dq_oe | output | 1 | Enable for the data drivers |
| sram_dq_in | input | DW | Data read back from the memory pins |

## Verification
The bench builds the controller with an 8 ns period and a 10-bit address, and keeps every default timing limit. With those values the read window is 6 cycles, the write strobe 5 cycles and the float gap 3 cycles, and each limit is missed by one cycle if a count is off by one. The small address space lets a behavioural memory hold the whole array. That memory returns a corrupted byte when it is read too early and flags drive overlap during the float gap, so the ends of the address range and back-to-back read/write turnarounds can all be reached in a short run.

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl #(
  parameter int AW            = 20,
  parameter int DW            = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 45,
  parameter int T_AA_NS       = 45,
  parameter int T_DOE_NS      = 22,
  parameter int T_HZOE_NS     = 18,
  parameter int T_WC_NS       = 45,
  parameter int T_PWE_NS      = 35,
  parameter int T_SD_NS       = 25,
  parameter int T_AW_NS       = 35
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          wr_done,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce1_n,
  output logic          sram_ce2,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_RD  = imax(imax(ns2cyc(T_AA_NS), ns2cyc(T_DOE_NS)), ns2cyc(T_RC_NS));
  localparam int N_WP  = imax(imax(ns2cyc(T_PWE_NS), ns2cyc(T_SD_NS) - 1),
                              imax(imax(ns2cyc(T_AW_NS) - 1, ns2cyc(T_WC_NS) - 2), 1));
  localparam int N_HZ  = ns2cyc(T_HZOE_NS);
  localparam int N_MAX = imax(imax(N_RD, N_WP), N_HZ);
  localparam int CW    = $clog2(N_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_RD_HZ, S_WR_SET, S_WR_PUL, S_WR_HOLD
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          sel;
  logic          cnt_end;

  assign cnt_end     = (cnt == '0);
  assign sel         = (state == S_RD) || (state == S_WR_SET) ||
                       (state == S_WR_PUL) || (state == S_WR_HOLD);
  assign req_ready   = (state == S_IDLE);
  assign sram_ce1_n  = !sel;
  assign sram_ce2    = sel;
  assign sram_we_n   = (state != S_WR_PUL);
  assign sram_oe_n   = (state != S_RD);
  assign sram_dq_oe  = (state == S_WR_SET) || (state == S_WR_PUL) || (state == S_WR_HOLD);
  assign sram_addr   = addr_q;
  assign sram_dq_out = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      wr_done  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      wr_done  <= 1'b0;
      if (!cnt_end) cnt <= cnt - 1'b1;
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          if (req_write) begin
            wdata_q <= req_wdata;
            state   <= S_WR_SET;
          end else begin
            cnt   <= CW'(N_RD - 1);
            state <= S_RD;
          end
        end
        S_RD: if (cnt_end) begin
          rd_data  <= sram_dq_in;
          rd_valid <= 1'b1;
          cnt      <= CW'(N_HZ - 1);
          state    <= S_RD_HZ;
        end
        S_RD_HZ: if (cnt_end) state <= S_IDLE;
        S_WR_SET: begin
          cnt   <= CW'(N_WP - 1);
          state <= S_WR_PUL;
        end
        S_WR_PUL: if (cnt_end) state <= S_WR_HOLD;
        S_WR_HOLD: begin
          wr_done <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
  parameter int AW            = 20,
  parameter int DW            = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_HZOE_NS     = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rd_valid,
  input logic          wr_done,
  input logic [AW-1:0] sram_addr,
  input logic          sram_ce1_n,
  input logic          sram_ce2,
  input logic          sram_we_n,
  input logic          sram_oe_n,
  input logic [DW-1:0] sram_dq_out,
  input logic          sram_dq_oe
);
  localparam int HZ_RAW = (T_HZOE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int N_HZ   = (HZ_RAW < 1) ? 1 : HZ_RAW;

  logic [7:0] since_oe;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_oe <= 8'(N_HZ);
    else if (!sram_oe_n)           since_oe <= 8'd0;
    else if (since_oe < 8'(N_HZ))  since_oe <= since_oe + 8'd1;
  end

  AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !sram_dq_oe)); // R1
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n)); // R4
  AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce1_n && sram_ce2 && sram_dq_oe)); // R4
  AST_ADDR_STEADY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_addr)); // R5
  AST_WR_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (!sram_ce1_n && sram_dq_oe && $stable(sram_addr) && $stable(sram_dq_out))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done); // R6
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R3
  AST_NO_DRIVE_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe); // R8
  AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (since_oe >= 8'(N_HZ))); // R7
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .AW(AW), .DW(DW), .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_HZOE_NS(T_HZOE_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .wr_done(wr_done), .sram_addr(sram_addr), .sram_ce1_n(sram_ce1_n),
  .sram_ce2(sram_ce2), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
  .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe)
);

// File: tb/sram_async_ctrl_test.sv
`timescale 1ns/1ps
module sram_async_ctrl_test;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int P  = 8;
  localparam int E_RD = 6;   // max(ceil(45/8), ceil(22/8)) R9
  localparam int E_WP = 5;   // ceil(35/8) R9
  localparam int E_HZ = 3;   // ceil(18/8) R9

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, wr_done, rd_valid;
  logic [DW-1:0] rd_data, sram_dq_out, sram_dq_in;
  logic [AW-1:0] sram_addr;
  logic sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe;

  always #4 clk = ~clk;

  sram_async_ctrl #(.AW(AW), .DW(DW), .CLK_PERIOD_NS(P)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .wr_done(wr_done), .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_addr(sram_addr), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural memory
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW-1:0] shadow [0:(1<<AW)-1];
  int rd_cyc = 0, wlow = 0, ds = 0, fl = 0;
  logic [DW-1:0] last_dq = '0;
  wire msel    = !sram_ce1_n && sram_ce2;
  wire mem_drv = msel && !sram_oe_n && sram_we_n;
  assign sram_dq_in = !mem_drv ? '0 :
                      ((rd_cyc + 1) * P >= 45) ? mem[sram_addr] : ~mem[sram_addr];

  always @(posedge clk) if (rst_n) begin
    rd_cyc <= mem_drv ? rd_cyc + 1 : 0;
    if (sram_dq_oe && (mem_drv || fl > 0)) chk(1'b0, "R7 bus overlap", fl, 0);
    if (mem_drv) fl <= E_HZ; else if (fl > 0) fl <= fl - 1;
    if (sram_dq_oe) begin
      ds <= (sram_dq_out == last_dq && ds > 0) ? ds + 1 : 1;
      last_dq <= sram_dq_out;
    end else ds <= 0;
    if (msel && !sram_we_n) wlow <= wlow + 1;
    else begin
      wlow <= 0;
      if (wlow > 0) begin
        chk(wlow * P >= 35, "R5 pulse width", wlow, 5);
        chk(ds * P >= 25, "R5 data setup", ds, 4);
        mem[sram_addr] <= sram_dq_out;
      end
    end
  end

  // scoreboard
  logic [8:0] exp_q [$];
  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) begin shadow[a] = d; exp_q.push_back({1'b0, 8'h00}); end
    else exp_q.push_back({1'b1, shadow[a]});
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 busy after accept", req_ready, 0);
  endtask

  int oe_run = 0, we_run = 0, sel_run = 0, since_oe = 100;
  logic prev_dq_oe = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (rd_valid || wr_done) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected response", 1, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(!(rd_valid && wr_done), "R6 single response", 1, 0);
        if (rd_valid) begin
          chk(e[8], "R3 response kind", 1, int'(e[8]));
          chk(rd_data == e[7:0], "R3 read data", rd_data, e[7:0]);
        end else chk(!e[8], "R6 response kind", 0, int'(e[8]));
      end
    end
    if (!sram_oe_n) oe_run++;
    else if (oe_run != 0) begin chk(oe_run == E_RD, "R3 R9 R10 read window", oe_run, E_RD); oe_run = 0; end
    if (!sram_we_n) we_run++;
    else if (we_run != 0) begin chk(we_run == E_WP, "R5 R9 strobe length", we_run, E_WP); we_run = 0; end
    if (msel) sel_run++;
    else if (sel_run != 0) begin chk(sel_run >= 6, "R10 select length", sel_run, 6); sel_run = 0; end
    if (sram_dq_oe && !sram_oe_n) chk(1'b0, "R8 drive with oe", 1, 0);
    if (sram_dq_oe && !prev_dq_oe) chk(since_oe >= E_HZ, "R7 float gap", since_oe, E_HZ);
    if (!sram_oe_n) since_oe = 0; else if (since_oe < 100) since_oe++;
    prev_dq_oe = sram_dq_oe;
  end

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin chk(1'b0, "watchdog", wd, 0); finish_up(); end
  end

  task automatic idle_check(input string tag);
    chk(req_ready && sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !sram_dq_oe,
        tag, {req_ready, sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe}, 6'b110110);
  endtask

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < (1 << AW); i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    idle_check("R1 reset state");
    chk(!rd_valid && !wr_done, "R1 no pulses in reset", {rd_valid, wr_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1 after reset");
    // directed: ends of the address range
    issue(1'b1, '0, 8'h3C);
    issue(1'b1, '1, 8'hC3);
    issue(1'b0, '0, 8'h00);
    issue(1'b0, '1, 8'h00);
    // write right after read (turnaround), overwrite, read back
    issue(1'b1, 10'h155, 8'h81);
    issue(1'b0, 10'h155, 8'h00);
    issue(1'b1, 10'h155, 8'h7E);
    issue(1'b0, 10'h155, 8'h00);
    issue(1'b0, 10'h2AA, 8'h00);
    // mixed stream
    lf = 16'hACE1;
    for (int n = 0; n < 80; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      issue(lf[0], AW'(lf[6:2]), lf[15:8]);
    end
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    @(negedge clk);
    idle_check("R1 parked after traffic");
    chk(exp_q.size() == 0, "R2 all responses", exp_q.size(), 0);
    finish_up();
  end
endmodule